// File: doc/BRIEF.md
# Pulse-Position Infrared Command Transmitter

This block turns one remote-control command into a pulse-position-modulated frame and drives it onto a serial line that feeds an infrared emitter. A command is a 16-bit address, built from sixteen external switch bits and sixteen fixed option bits, followed by an 8-bit data code and its bitwise complement. Marks (active periods) are chopped by a carrier of roughly one-third duty. Spaces (quiet periods) keep the line low.

A one-cycle start strobe launches a full frame and opens a fixed frame period of 192 time units. A unit is 0.5625 ms, so the period is 108 ms. A hold flag tells the block that the key is still pressed. If hold is high when the period runs out, a short repeat frame is sent in the period that follows. If hold is low, the block goes idle. The clock frequency and the carrier frequency are parameters, and every duration is derived from them.

Top module: `irtx_ppm_tx`

## Requirements
- R1: After reset, and whenever no frame period is open, `tx_out` is 0 and `tx_busy_n` is 1. A high `hold` with no start strobe does not open a period.
- R2: A full frame opens with a 16-unit mark, followed by an 8-unit space. One unit is (CLK_HZ/16000)*9 clock cycles, and unit 0 begins in the first cycle after the clock edge that accepts `start`.
- R3: Each payload bit is a 1-unit mark followed by a space: 1 unit for a zero, 3 units for a one. After the last bit comes a 1-unit closing mark. The line then stays low until the period ends.
- R4: The 32 payload bits go out in this order: address bits 0 to 15, then data bits 0 to 7, then the complement of data bits 0 to 7. Each field is sent least significant bit first.
- R5: Address bit i, for i in 0..7, is `sw_bits[i] | opt_bits[i]`.
- R6: Address bit 8+i, for i in 0..7, equals address bit i when `sw_bits[8+i] | opt_bits[8+i]` is 1, and equals its complement when that OR is 0.
- R7: During a mark, `tx_out` is 1 exactly when (cycles since the current frame began) mod CAR_CYC is below CAR_ON. Here CAR_CYC = CLK_HZ/CARRIER_HZ and CAR_ON = (CAR_CYC+1)/3. During a space, `tx_out` is 0.
- R8: A period lasts 192 units. If `hold` is 1 in the last cycle of a period, a repeat frame starts in the next cycle. A repeat frame is a 16-unit mark, a 4-unit space and a 1-unit mark, with no payload. Repeat frames chain while `hold` stays high.
- R9: If `hold` is 0 in the last cycle of a period, the block is idle from the next cycle on.
- R10: `tx_busy_n` is 0 in every cycle of an open period, for full and repeat frames alike.
- R11: A `start` strobe that arrives while a period is open, including in its last cycle, is ignored.
- R12: The switch, option and data inputs are captured when `start` is accepted. Changing them during the frame does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe for a full frame |
| hold | input | 1 | Key still pressed; requests a repeat frame at period end |
| sw_bits | input | 16 | External switch bits (low byte: address; high byte: pass/invert control) |
| opt_bits | input | 16 | Fixed option bits ORed with the switch bits |
| data_code | input | 8 | Command data byte |
| tx_out | output | 1 | Carrier-modulated serial line |
| tx_busy_n | output | 1 | Active-low transmit indicator |

## Verification
The bench builds the block with CLK_HZ=32000 and CARRIER_HZ=4000. This gives an 18-cycle unit, an 8-cycle carrier with 3 cycles on, and a 3456-cycle frame period. The bench clock still runs at 50 MHz; only the parameters are scaled down. At this scale every cycle of every frame can be compared against a model computed in the bench. The same run covers chains of repeat frames, start strobes and input changes landing mid-period and on the period's last cycle, and many random address and data codes.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    // Durations, counted in units of 0.5625 ms
    localparam int HDR_UNITS        = 16;
    localparam int GAP_FULL_UNITS   = 8;
    localparam int GAP_REP_UNITS    = 4;
    localparam int MARK_UNITS       = 1;
    localparam int ZERO_SPACE_UNITS = 1;
    localparam int ONE_SPACE_UNITS  = 3;
    localparam int PERIOD_UNITS     = 192;

    localparam int HALF_W       = 8;
    localparam int PAYLOAD_BITS = 4 * HALF_W;
    localparam int PU_W         = $clog2(PERIOD_UNITS);
    localparam int SEG_W        = $clog2(HDR_UNITS) + 1;
    localparam int BIT_W        = $clog2(PAYLOAD_BITS);

    typedef enum logic [2:0] {
        SEG_LEAD, SEG_GAP, SEG_MARK, SEG_SPACE, SEG_STOP, SEG_REST
    } seg_e;

    typedef enum logic {FRM_FULL, FRM_REPEAT} frm_e;

    // Bit 0 of the packed struct is sent first
    typedef struct packed {
        logic [HALF_W-1:0]   data_inv;
        logic [HALF_W-1:0]   data;
        logic [2*HALF_W-1:0] addr;
    } payload_t;

    function automatic logic [SEG_W-1:0] seg_units(input seg_e s, input frm_e f, input logic bitv);
        case (s)
            SEG_LEAD:  return SEG_W'(HDR_UNITS);
            SEG_GAP:   return (f == FRM_FULL) ? SEG_W'(GAP_FULL_UNITS) : SEG_W'(GAP_REP_UNITS);
            SEG_SPACE: return bitv ? SEG_W'(ONE_SPACE_UNITS) : SEG_W'(ZERO_SPACE_UNITS);
            default:   return SEG_W'(MARK_UNITS);
        endcase
    endfunction

endpackage

// File: rtl/irtx_frame_pack.sv
module irtx_frame_pack
    import irtx_pkg::*;
(
    input  logic [2*HALF_W-1:0] sw_bits,
    input  logic [2*HALF_W-1:0] opt_bits,
    input  logic [HALF_W-1:0]   data_code,
    output payload_t            payload
);
    logic [HALF_W-1:0] addr_lo;
    logic [HALF_W-1:0] pass_ctl;
    logic [HALF_W-1:0] addr_hi;

    assign addr_lo  = sw_bits[HALF_W-1:0] | opt_bits[HALF_W-1:0];
    assign pass_ctl = sw_bits[2*HALF_W-1:HALF_W] | opt_bits[2*HALF_W-1:HALF_W];

    for (genvar i = 0; i < HALF_W; i++) begin : g_hi
        assign addr_hi[i] = pass_ctl[i] ? addr_lo[i] : ~addr_lo[i];
    end

    assign payload.addr     = {addr_hi, addr_lo};
    assign payload.data     = data_code;
    assign payload.data_inv = ~data_code;
endmodule

// File: rtl/irtx_timebase.sv
module irtx_timebase #(
    parameter int UNIT_CYC = 28125,
    parameter int CAR_CYC  = 1315,
    parameter int CAR_ON   = 438
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic unit_tick,
    output logic car_on
);
    localparam int UW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam int CW = (CAR_CYC > 1) ? $clog2(CAR_CYC) : 1;

    logic [UW-1:0] unit_cnt;
    logic [CW-1:0] car_cnt;

    assign unit_tick = (unit_cnt == UW'(UNIT_CYC - 1));
    assign car_on    = (car_cnt < CW'(CAR_ON));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            unit_cnt <= '0;
            car_cnt  <= '0;
        end else begin
            unit_cnt <= unit_tick ? '0 : unit_cnt + 1'b1;
            car_cnt  <= (car_cnt == CW'(CAR_CYC - 1)) ? '0 : car_cnt + 1'b1;
        end
    end

    AST_UNIT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (unit_tick && !clr) |=> (unit_cnt == '0)); // R2
endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
    import irtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     hold,
    input  logic     unit_tick,
    input  payload_t payload_in,
    output logic     active,
    output logic     mark_on,
    output logic     launch
);
    frm_e                    ftype;
    seg_e                    seg;
    logic [SEG_W-1:0]        seg_cnt;
    logic [BIT_W-1:0]        bit_idx;
    logic [PU_W-1:0]         pu;
    logic [PAYLOAD_BITS-1:0] shreg;
    logic                    period_last;
    logic                    seg_done;

    assign period_last = unit_tick && (pu == PU_W'(PERIOD_UNITS - 1));
    assign launch      = (!active && start) || (active && period_last && hold);
    assign seg_done    = unit_tick && (seg != SEG_REST)
                         && (seg_cnt == seg_units(seg, ftype, shreg[0]) - SEG_W'(1));
    assign mark_on     = active && (seg == SEG_LEAD || seg == SEG_MARK || seg == SEG_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ftype   <= FRM_FULL;
            seg     <= SEG_REST;
            seg_cnt <= '0;
            bit_idx <= '0;
            pu      <= '0;
            shreg   <= '0;
        end else if (launch) begin
            active  <= 1'b1;
            pu      <= '0;
            seg     <= SEG_LEAD;
            seg_cnt <= '0;
            bit_idx <= '0;
            if (!active) begin
                ftype <= FRM_FULL;
                shreg <= payload_in;
            end else begin
                ftype <= FRM_REPEAT;
            end
        end else if (active && period_last) begin
            active <= 1'b0;
            seg    <= SEG_REST;
        end else if (active && unit_tick) begin
            pu <= pu + 1'b1;
            if (seg_done) begin
                seg_cnt <= '0;
                case (seg)
                    SEG_LEAD:  seg <= SEG_GAP;
                    SEG_GAP:   seg <= (ftype == FRM_FULL) ? SEG_MARK : SEG_STOP;
                    SEG_MARK:  seg <= SEG_SPACE;
                    SEG_SPACE: begin
                        shreg <= shreg >> 1;
                        if (bit_idx == BIT_W'(PAYLOAD_BITS - 1)) begin
                            seg <= SEG_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            seg     <= SEG_MARK;
                        end
                    end
                    default:   seg <= SEG_REST;
                endcase
            end else if (seg != SEG_REST) begin
                seg_cnt <= seg_cnt + 1'b1;
            end
        end
    end

    AST_LEAD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (active && seg == SEG_LEAD) |-> (pu < PU_W'(HDR_UNITS))); // R2
    AST_STOP_AFTER_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (active && seg == SEG_STOP && ftype == FRM_FULL)
        |-> (pu >= PU_W'(HDR_UNITS + GAP_FULL_UNITS + 2 * PAYLOAD_BITS))); // R3
    AST_PERIOD_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (active && period_last && !hold) |=> !active); // R9
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (active && start && !period_last) |=> (active && pu >= $past(pu))); // R11
endmodule

// File: rtl/irtx_ppm_tx.sv
module irtx_ppm_tx
    import irtx_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int CARRIER_HZ = 38_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        hold,
    input  logic [15:0] sw_bits,
    input  logic [15:0] opt_bits,
    input  logic [7:0]  data_code,
    output logic        tx_out,
    output logic        tx_busy_n
);
    localparam int UNIT_CYC = (CLK_HZ / 16000) * 9;
    localparam int CAR_CYC  = CLK_HZ / CARRIER_HZ;
    localparam int CAR_ON   = (CAR_CYC + 1) / 3;

    payload_t payload;
    logic     unit_tick;
    logic     car_on;
    logic     active;
    logic     mark_on;
    logic     launch;

    irtx_frame_pack u_pack (
        .sw_bits   (sw_bits),
        .opt_bits  (opt_bits),
        .data_code (data_code),
        .payload   (payload)
    );

    irtx_timebase #(
        .UNIT_CYC (UNIT_CYC),
        .CAR_CYC  (CAR_CYC),
        .CAR_ON   (CAR_ON)
    ) u_time (
        .clk       (clk),
        .rst       (rst),
        .clr       (launch),
        .unit_tick (unit_tick),
        .car_on    (car_on)
    );

    irtx_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hold       (hold),
        .unit_tick  (unit_tick),
        .payload_in (payload),
        .active     (active),
        .mark_on    (mark_on),
        .launch     (launch)
    );

    assign tx_out    = mark_on && car_on;
    assign tx_busy_n = !active;

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        tx_busy_n |-> !tx_out); // R1
    AST_CARRIER_PHASE: assert property (@(posedge clk) disable iff (rst)
        launch |=> car_on); // R7
endmodule

// File: tb/irtx_ppm_tx_tb_top.sv
module irtx_ppm_tx_tb_top;
    localparam int CLK_HZ     = 32000;
    localparam int CARRIER_HZ = 4000;
    localparam int UNIT       = (CLK_HZ / 16000) * 9;
    localparam int CAR        = CLK_HZ / CARRIER_HZ;
    localparam int CON        = (CAR + 1) / 3;
    localparam int PER_CYC    = 192 * UNIT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        hold = 1'b0;
    logic [15:0] sw = '0;
    logic [15:0] opt = '0;
    logic [7:0]  data = '0;
    logic        tx_out;
    logic        busy_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irtx_ppm_tx #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ)) dut_i (
        .clk (clk), .rst (rst), .start (start), .hold (hold),
        .sw_bits (sw), .opt_bits (opt), .data_code (data),
        .tx_out (tx_out), .tx_busy_n (busy_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5 R6 R4: expected payload, bit 0 sent first
    function automatic logic [31:0] model_payload(input logic [15:0] s, input logic [15:0] o,
                                                  input logic [7:0] d);
        logic [7:0] lo, ctl, hi;
        lo  = s[7:0] | o[7:0];
        ctl = s[15:8] | o[15:8];
        for (int i = 0; i < 8; i++) hi[i] = ctl[i] ? lo[i] : !lo[i];
        return {~d, d, hi, lo};
    endfunction

    // R2 R3 R8: is unit u of the frame a mark
    function automatic bit unit_mark(input bit rep, input logic [31:0] p, input int u);
        int pos;
        if (u < 16) return 1'b1;
        if (rep) return (u == 20);
        pos = 24;
        for (int i = 0; i < 32; i++) begin
            if (u == pos) return 1'b1;
            pos += p[i] ? 4 : 2;
        end
        return (u == pos);
    endfunction

    task automatic run_frame(input bit rep, input logic [31:0] p, input bit hold_end,
                             input string tag, input bit disturb);
        int bad_hdr = 0;
        int bad_pay = 0;
        int bad_busy = 0;
        hold = hold_end;
        for (int k = 0; k < PER_CYC; k++) begin
            int  u;
            bit  expv;
            u    = k / UNIT;
            expv = unit_mark(rep, p, u) && ((k % CAR) < CON);
            if (tx_out !== expv) begin
                if (u < 24) bad_hdr++;
                else bad_pay++;
            end
            if (busy_n !== 1'b0) bad_busy++;
            if (disturb) begin
                start = ((k % 500) == 7) || (k == PER_CYC - 1);
                if (k == 1000) begin
                    sw   = ~sw;
                    opt  = ~opt;
                    data = ~data;
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad_hdr == 0, rep ? "R8 R7 repeat lead" : "R2 R7 lead and gap", bad_hdr, 0);
        chk(bad_pay == 0, tag, bad_pay, 0);
        chk(bad_busy == 0, "R10 busy low in period", bad_busy, 0);
    endtask

    task automatic launch_full();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_idle(input string tag, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (tx_out !== 1'b0 || busy_n !== 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(tx_out === 1'b0 && busy_n === 1'b1, "R1 reset state", {tx_out, busy_n}, 1);
        rst = 1'b0;
        hold = 1'b1;
        check_idle("R1 hold alone stays idle", 60);
        hold = 1'b0;

        // Directed: high address byte fully inverted
        sw = 16'h0019; opt = 16'h0000; data = 8'h3C;
        p = model_payload(sw, opt, data);
        launch_full();
        run_frame(1'b0, p, 1'b0, "R3 R4 R5 R6 inverted high byte", 1'b0);
        check_idle("R9 idle after frame", 40);

        // Directed: high address byte passed, then repeat chain
        sw = 16'h0F01; opt = 16'hF080; data = 8'hA5;
        p = model_payload(sw, opt, data);
        launch_full();
        run_frame(1'b0, p, 1'b1, "R3 R4 R5 R6 passed high byte", 1'b0);
        run_frame(1'b1, p, 1'b1, "R8 first repeat tail", 1'b0);
        run_frame(1'b1, p, 1'b0, "R8 chained repeat tail", 1'b0);
        check_idle("R9 idle after repeat", 40);

        // Directed: start strobes and input changes during the period
        sw = 16'hFFFF; opt = 16'h0000; data = 8'h00;
        p = model_payload(sw, opt, data);
        launch_full();
        run_frame(1'b0, p, 1'b0, "R11 R12 disturbed frame payload", 1'b1);
        check_idle("R11 start on last cycle ignored", 40);

        // Constrained random
        for (int n = 0; n < 8; n++) begin
            bit h;
            sw   = 16'($urandom);
            opt  = 16'($urandom);
            data = 8'($urandom);
            h    = 1'($urandom);
            p = model_payload(sw, opt, data);
            launch_full();
            run_frame(1'b0, p, h, "R3 R4 R5 R6 random frame", 1'b0);
            if (h) run_frame(1'b1, p, 1'b0, "R8 random repeat", 1'b0);
            check_idle("R9 random idle", 20);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule